// File: doc/BRIEF.md
# I2C Slave Dual-Address Matcher

This block decides whether the address phase of an I2C transfer is meant for this slave. After each START or repeated START it looks at the first received byte. For a 10-bit address it also looks at the second byte. It compares them against two own addresses that software programs:

- A primary address, which can be 7-bit or 10-bit.
- A secondary address, which is 7-bit only. A mask field can drop its low bits from the comparison.

For every address byte it evaluates, the block produces a one-cycle ACK/NACK decision for the bit shifter. On a match it sets a sticky match flag in a status word, together with the matched address code and the transfer direction. It keeps SCL stretched until software clears the flag through a clear strobe.

A 10-bit match is reported as the 7-bit code `11110` followed by address bits 9 and 8. After a 10-bit write has fully matched, a repeated START followed by the header byte with R/W=1 matches again by itself. This is the usual way to switch the transfer to a read. Bit-level SCL/SDA timing and data bytes are handled elsewhere; the block only receives byte strobes and START/STOP pulses.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the status word is zero, `ackValid` is 0 and `sclHold` is 0.
- R2: When the primary enable (bit 15) is set and the mode bit (bit 10) is 0, a first byte whose bits 7:1 equal primary bits 7:1 is ACKed. It also sets the flag (status bit 3), loads the address code (status bits 23:17) with the received 7-bit address, and loads the direction (status bit 16) with the byte's bit 0, where 1 means the slave transmits.
- R3: When the secondary enable (bit 15) is set, a first byte matches the secondary address (bits 7:1) if it differs from it only in the n least significant address bits. Here n is the mask field at bits 10:8. A mask of 7 disables the secondary comparison.
- R4: In 10-bit mode (bit 10 = 1) the first byte is treated as a header. A header of `11110`, primary bits 9:8 and R/W=0 is ACKed without setting the flag. A following byte equal to primary bits 7:0 is then ACKed and sets the flag, with code `{11110, bits 9:8}` and direction 0. A wrong second byte is NACKed.
- R5: After a full 10-bit match, a repeated START followed by the header with R/W=1 matches by itself, with direction 1. Without a prior full match since the last STOP, that header is NACKed. A STOP forgets the prior match.
- R6: A first byte matching neither enabled address, or matching only a disabled one, is NACKed and leaves the status word unchanged.
- R7: The flag stays set until a clear strobe arrives with clear bit 3 set. A clear strobe without bit 3 has no effect. `sclHold` equals the flag.
- R8: `ackValid` pulses for one cycle, in the cycle after an evaluated address byte strobe, with `ackGo` giving the decision. Bytes outside the address phase produce no `ackValid`.
- R9: The address code and direction keep their value until the next match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| priCfg | input | 16 | Primary own address: enable 15, 10-bit mode 10, address 9:0 or 7:1 |
| secCfg | input | 16 | Secondary own address: enable 15, mask 10:8, address 7:1 |
| startSeen | input | 1 | START or repeated START pulse |
| stopSeen | input | 1 | STOP pulse |
| byteValid | input | 1 | A received byte is on byteData |
| byteData | input | 8 | Received byte, R/W in bit 0 |
| clrStrobe | input | 1 | Write to the clear register |
| clrBits | input | 8 | Clear register value; bit 3 clears the flag |
| statusWord | output | 24 | Code 23:17, direction 16, flag 3, other bits 0 |
| ackValid | output | 1 | One-cycle pulse: an ACK decision is ready |
| ackGo | output | 1 | 1 = ACK, 0 = NACK |
| sclHold | output | 1 | Stretch SCL while the flag is set |

## Verification
The hardest situation to reach is the repeated-START read that re-matches on the header byte alone. It needs a full two-byte 10-bit write match first, with no STOP in between. The condition is easy to break by a STOP, by a new write header, or by a wrong second byte.

The random stimulus draws header bytes built from the programmed 10-bit address, and correct second bytes, far more often than chance would. It often omits STOP between iterations, so repeated STARTs follow earlier matches. Directed sequences add the armed read, the unarmed read and the read after STOP.

// File: rtl/i2cam_pkg.sv
`timescale 1ns/1ps
package i2cam_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND} phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setMatch;
    logic tenCode;
    logic dirVal;
  } matchCtl_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic pri7;
    logic hdr10;
    logic low10;
    logic sec;
  } hitVec_t;
endpackage

// File: rtl/i2cam_datapath.sv
`timescale 1ns/1ps
module i2cam_datapath
  import i2cam_pkg::*;
#(
  parameter int CFG_W    = 16,
  parameter int STAT_W   = 24,
  parameter int CLR_W    = 8,
  parameter int EN_BIT   = 15,
  parameter int MODE_BIT = 10,
  parameter int MASK_LSB = 8,
  parameter int MASK_W   = 3,
  parameter int CODE_LSB = 17,
  parameter int DIR_BIT  = 16,
  parameter int FLAG_BIT = 3,
  parameter int CLR_BIT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_W-1:0]  priCfg,
  input  logic [CFG_W-1:0]  secCfg,
  input  logic [7:0]        byteData,
  input  logic              clrStrobe,
  input  logic [CLR_W-1:0]  clrBits,
  input  matchCtl_t         ctl,
  output hitVec_t           hits,
  output logic              rwBit,
  output logic              matchFlag,
  output logic [STAT_W-1:0] statusWord
);
  localparam int CODE_W = 7;
  localparam logic [MASK_W-1:0] MASK_OFF = {MASK_W{1'b1}};
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  logic              priOn, priTen, secOn;
  logic [CODE_W-1:0] rxAddr, hdrCode, careBit, secDiff;
  logic [MASK_W-1:0] secMask;
  logic [CODE_W-1:0] codeQ;
  logic              dirQ;

  assign priOn   = priCfg[EN_BIT];
  assign priTen  = priCfg[MODE_BIT];
  assign secOn   = secCfg[EN_BIT];
  assign secMask = secCfg[MASK_LSB +: MASK_W];
  assign rxAddr  = byteData[7:1];
  assign rwBit   = byteData[0];
  assign hdrCode = {TEN_PREFIX, priCfg[9:8]};

  // per-bit care vector for the secondary mask
  for (genvar gi = 0; gi < CODE_W; gi++) begin : g_care
    assign careBit[gi] = (secMask <= MASK_W'(gi));
  end

  assign secDiff    = (rxAddr ^ secCfg[7:1]) & careBit;
  assign hits.sec   = secOn && (secMask != MASK_OFF) && (secDiff == '0);
  assign hits.pri7  = priOn && !priTen && (rxAddr == priCfg[7:1]);
  assign hits.hdr10 = priOn && priTen && (rxAddr == hdrCode);
  assign hits.low10 = priOn && priTen && (byteData == priCfg[7:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
      codeQ     <= '0;
      dirQ      <= 1'b0;
    end else if (ctl.setMatch) begin
      matchFlag <= 1'b1;
      codeQ     <= ctl.tenCode ? hdrCode : rxAddr;
      dirQ      <= ctl.dirVal;
    end else if (clrStrobe && clrBits[CLR_BIT]) begin
      matchFlag <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[CODE_LSB +: CODE_W] = codeQ;
    statusWord[DIR_BIT]  = dirQ;
    statusWord[FLAG_BIT] = matchFlag;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    matchFlag && !(clrStrobe && clrBits[CLR_BIT]) |=> matchFlag); // R7
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.setMatch |=> $stable(codeQ) && $stable(dirQ)); // R9
  AST_TEN_FORM: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setMatch && ctl.tenCode |=> codeQ[6:2] == TEN_PREFIX); // R4
endmodule

// File: rtl/i2cam_control.sv
`timescale 1ns/1ps
module i2cam_control
  import i2cam_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startSeen,
  input  logic      stopSeen,
  input  logic      byteValid,
  input  logic      rwBit,
  input  hitVec_t   hits,
  output matchCtl_t ctl,
  output logic      ackValid,
  output logic      ackGo
);
  phase_t phase, nextPhase;
  logic   armed, nextArmed;
  logic   decide, go;

  always_comb begin
    ctl       = '0;
    nextPhase = phase;
    nextArmed = armed;
    decide    = 1'b0;
    go        = 1'b0;
    if (stopSeen) begin
      nextPhase = PH_IDLE;
      nextArmed = 1'b0;
    end else if (startSeen) begin
      nextPhase = PH_FIRST;
    end else if (byteValid) begin
      unique case (phase)
        PH_FIRST: begin
          decide    = 1'b1;
          nextPhase = PH_IDLE;
          if (hits.pri7) begin
            go = 1'b1;
            ctl.setMatch = 1'b1;
            ctl.dirVal   = rwBit;
          end else if (hits.hdr10 && !rwBit) begin
            go        = 1'b1;
            nextArmed = 1'b0;
            nextPhase = PH_SECOND;
          end else if (hits.hdr10 && armed) begin
            go = 1'b1;
            ctl.setMatch = 1'b1;
            ctl.tenCode  = 1'b1;
            ctl.dirVal   = 1'b1;
          end else if (hits.sec) begin
            go = 1'b1;
            ctl.setMatch = 1'b1;
            ctl.dirVal   = rwBit;
          end
        end
        PH_SECOND: begin
          decide    = 1'b1;
          nextPhase = PH_IDLE;
          nextArmed = hits.low10;
          if (hits.low10) begin
            go = 1'b1;
            ctl.setMatch = 1'b1;
            ctl.tenCode  = 1'b1;
            ctl.dirVal   = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      armed    <= 1'b0;
      ackValid <= 1'b0;
      ackGo    <= 1'b0;
    end else begin
      phase    <= nextPhase;
      armed    <= nextArmed;
      ackValid <= decide;
      ackGo    <= go;
    end
  end

  AST_STOP_FORGETS: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> phase == PH_IDLE && !armed); // R5
  AST_ACK_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(byteValid) && $past(phase) != PH_IDLE); // R8
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid); // R8
endmodule

// File: rtl/i2c_addr_match.sv
`timescale 1ns/1ps
module i2c_addr_match
  import i2cam_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] priCfg,
  input  logic [15:0] secCfg,
  input  logic        startSeen,
  input  logic        stopSeen,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        clrStrobe,
  input  logic [7:0]  clrBits,
  output logic [23:0] statusWord,
  output logic        ackValid,
  output logic        ackGo,
  output logic        sclHold
);
  matchCtl_t ctl;
  hitVec_t   hits;
  logic      rwBit, matchFlag;

  i2cam_control u_ctl (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .byteValid(byteValid), .rwBit(rwBit), .hits(hits), .ctl(ctl),
    .ackValid(ackValid), .ackGo(ackGo)
  );

  i2cam_datapath u_dp (
    .clk(clk), .rstN(rstN), .priCfg(priCfg), .secCfg(secCfg),
    .byteData(byteData), .clrStrobe(clrStrobe), .clrBits(clrBits),
    .ctl(ctl), .hits(hits), .rwBit(rwBit), .matchFlag(matchFlag),
    .statusWord(statusWord)
  );

  assign sclHold = matchFlag;

  AST_MATCH_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> ackValid && ackGo); // R2
  AST_NACK_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && !ackGo |-> !$rose(matchFlag)); // R6
endmodule

// File: tb/sim_i2c_addr_match.sv
`timescale 1ns/1ps
module sim_i2c_addr_match;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic [15:0] priCfg = '0, secCfg = '0;
  logic        startSeen = 1'b0, stopSeen = 1'b0, byteValid = 1'b0, clrStrobe = 1'b0;
  logic [7:0]  byteData = '0, clrBits = '0;
  logic [23:0] statusWord;
  logic        ackValid, ackGo, sclHold;

  i2c_addr_match u0 (
    .clk(clk), .rstN(rstN), .priCfg(priCfg), .secCfg(secCfg),
    .startSeen(startSeen), .stopSeen(stopSeen), .byteValid(byteValid),
    .byteData(byteData), .clrStrobe(clrStrobe), .clrBits(clrBits),
    .statusWord(statusWord), .ackValid(ackValid), .ackGo(ackGo), .sclHold(sclHold)
  );

  int checks = 0, errors = 0;
  // reference state: phase 0 idle, 1 first byte, 2 second byte
  int       mPhase = 0;
  bit       mArmed = 0, mFlag = 0, mDir = 0;
  bit [6:0] mCode = '0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [23:0] expStatus();
    return {mCode, mDir, 12'b0, mFlag, 3'b0};
  endfunction

  function automatic bit secHit(input bit [6:0] a);
    int n = int'(secCfg[10:8]);
    if (!secCfg[15] || n == 7) return 0;
    return ((a ^ secCfg[7:1]) >> n) == 0;
  endfunction

  task automatic modelByte(input bit [7:0] b, output bit ev, output bit eg);
    bit [6:0] hdr = {5'b11110, priCfg[9:8]};
    bit [6:0] a   = b[7:1];
    ev = 0; eg = 0;
    if (mPhase == 1) begin
      ev = 1; mPhase = 0;
      if (priCfg[15] && !priCfg[10] && a == priCfg[7:1]) begin
        eg = 1; mFlag = 1; mCode = a; mDir = b[0];
      end else if (priCfg[15] && priCfg[10] && a == hdr && !b[0]) begin
        eg = 1; mArmed = 0; mPhase = 2;
      end else if (priCfg[15] && priCfg[10] && a == hdr && mArmed) begin
        eg = 1; mFlag = 1; mCode = hdr; mDir = 1;
      end else if (secHit(a)) begin
        eg = 1; mFlag = 1; mCode = a; mDir = b[0];
      end
    end else if (mPhase == 2) begin
      ev = 1; mPhase = 0;
      if (priCfg[15] && priCfg[10] && b == priCfg[7:0]) begin
        eg = 1; mFlag = 1; mCode = hdr; mDir = 0; mArmed = 1;
      end else mArmed = 0;
    end
  endtask

  task automatic doStart();
    @(negedge clk) startSeen = 1;
    @(negedge clk) startSeen = 0;
    mPhase = 1;
  endtask

  task automatic doStop();
    @(negedge clk) stopSeen = 1;
    @(negedge clk) stopSeen = 0;
    mPhase = 0; mArmed = 0;
  endtask

  task automatic sendByte(input bit [7:0] b, input string req);
    bit ev, eg;
    modelByte(b, ev, eg);
    @(negedge clk) begin byteValid = 1; byteData = b; end
    @(negedge clk) byteValid = 0;
    chk({req, " ackValid"}, ackValid, ev);
    if (ev) chk({req, " ackGo"}, ackGo, eg);
    chk({req, " status"}, statusWord, expStatus());
    chk({req, " sclHold"}, sclHold, mFlag);
  endtask

  task automatic doClear(input bit [7:0] bits, input string req);
    @(negedge clk) begin clrStrobe = 1; clrBits = bits; end
    @(negedge clk) clrStrobe = 0;
    if (bits[3]) mFlag = 0;
    chk({req, " status"}, statusWord, expStatus());
    chk({req, " sclHold"}, sclHold, mFlag);
  endtask

  function automatic bit [7:0] pickByte();
    unique case ($urandom_range(0, 4))
      0: return {priCfg[7:1], 1'($urandom)};
      1: return {secCfg[7:1] ^ 7'($urandom_range(0, 7)), 1'($urandom)};
      2, 3: return {5'b11110, priCfg[9:8], 1'($urandom)};
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic randCfg();
    priCfg = {($urandom_range(0, 3) != 0), 4'b0, 1'($urandom), 10'($urandom)};
    secCfg = {($urandom_range(0, 3) != 0), 4'b0, 3'($urandom), 7'($urandom), 1'b0};
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 status", statusWord, 24'h0);
    chk("R1 ackValid", ackValid, 0);
    chk("R1 sclHold", sclHold, 0);

    // R2: 7-bit primary 0x3A, write then code/dir fields
    priCfg = 16'h8000 | (16'h3A << 1); secCfg = 16'h0;
    doStart(); sendByte(8'h74, "R2 pri7 write");
    sendByte(8'h11, "R8 data byte ignored");
    doClear(8'hF7, "R7 clear without bit3");
    doClear(8'h08, "R7 clear bit3");
    doStop();
    // R6: disabled primary
    priCfg[15] = 0;
    doStart(); sendByte(8'h75, "R6 disabled pri");
    doStop();
    // R3: secondary 0x51 mask 2 matches 0x52
    secCfg = 16'h8000 | (16'd2 << 8) | (16'h51 << 1);
    doStart(); sendByte(8'hA5, "R3 sec masked hit");
    doClear(8'h08, "R7 clear");
    secCfg[10:8] = 3'd1;
    doStart(); sendByte(8'hA5, "R3 sec mask too small");
    secCfg[10:8] = 3'd7;
    doStart(); sendByte(8'hA2, "R3 sec mask 7 off");
    doStop();
    // R4/R5: 10-bit primary 0x2C7, header 0x7A
    priCfg = 16'h8400 | 16'h02C7; secCfg = 16'h0;
    doStart(); sendByte(8'hF5, "R5 unarmed read header");
    doStart(); sendByte(8'hF4, "R4 header write");
    sendByte(8'hC6, "R4 wrong second byte");
    doStart(); sendByte(8'hF4, "R4 header write");
    sendByte(8'hC7, "R4 second byte match");
    doClear(8'h08, "R7 clear");
    doStart(); sendByte(8'hF5, "R5 repeated start read");
    doClear(8'h08, "R9 clear keeps code");
    doStop();
    doStart(); sendByte(8'hF5, "R5 read after stop");
    doStop();

    // random mix
    randCfg();
    for (int it = 0; it < 600; it++) begin
      if ($urandom_range(0, 3) == 0) randCfg();
      doStart();
      sendByte(pickByte(), "R2 R3 R6 random first");
      if (mPhase == 2)
        sendByte($urandom_range(0, 1) ? priCfg[7:0] : 8'($urandom), "R4 random second");
      if ($urandom_range(0, 2) == 0) begin
        doStart();
        sendByte({5'b11110, priCfg[9:8], 1'b1}, "R5 random reread");
      end
      sendByte(8'($urandom), "R8 random data");
      if ($urandom_range(0, 1) == 0)
        doClear($urandom_range(0, 4) < 3 ? 8'h08 : 8'($urandom), "R7 random clear");
      if ($urandom_range(0, 1) == 0) doStop();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule